// File: doc/BRIEF.md
# SD Card SPI-Mode Initializer

This block is a hardware sequencer that takes an SD or SDHC card from power-up to the point where it is ready for SPI-mode data transfer. It drives a byte-level SPI port. For each byte it raises a one-cycle issue strobe with the byte to send, then waits for an acknowledge strobe that returns the byte received. It also drives the card's chip select and an enable for the port. A pulse on `start` runs the whole bring-up: wake-up clocks, reset command, interface-condition check, the repeated operating-condition handshake, reading of the capacity bit, and block-length setup when the card needs it.

When the sequence ends, the block holds either `done` or `error`. With `done` it also reports in `block_addressed` whether the card takes block numbers (high capacity) or byte offsets. A card that answers the interface-condition command takes the high-capacity path. A card that stays silent or rejects that command takes the legacy path, which is always byte addressed.

Top module: `sd_spi_init`

## Requirements
- R1: After reset, `done`, `error`, `block_addressed` and `spi_en` are 0, `spi_cs_n` is 1 and no byte is issued until `start`.
- R2: After `start`, the first 16 bytes issued are 0xFF with `spi_cs_n` = 1 and `spi_en` = 1.
- R3: Each command goes out as two 0xFF bytes followed by a 6-byte frame, all with `spi_cs_n` = 0. The frame is 0x40|index, four argument bytes with the most significant first, then a check byte. The reset command (index 0) is 40 00 00 00 00 95, the interface-condition command (index 8) is 48 00 00 01 AA 87, and every other frame ends in 0xFF.
- R4: After a frame, 0xFF bytes are issued until a received byte has bit 7 clear, which is taken as the response. If 256 bytes pass without such a byte, the command has timed out. A timeout on the reset command ends in `error`.
- R5: A response to the reset command or the application-prefix command (index 55) is accepted when (response AND 0x7E) = 0. Any other value ends in `error`.
- R6: If the interface-condition command times out or its response fails the 0x7E mask, the legacy path is taken. Otherwise four more bytes are read; the third must be 0x01 and the fourth 0xAA. If either check fails, the sequence ends in `error` at once.
- R7: The operating-condition command is sent as the prefix frame followed by 69 xx 00 00 00 FF, where xx is 0x40 on the high-capacity path and 0x00 on the legacy path. A response of 0x01 repeats the pair, 0x00 moves on, and any other value ends in `error`.
- R8: On the high-capacity path, command 58 (7A 00 00 00 00 FF) is sent and four bytes follow its response. Bit 6 of the first of these sets `block_addressed`; the other three bytes are ignored.
- R9: Byte-addressed cards, including every legacy-path card, then get command 16 (50 00 00 02 00 FF), which must return exactly 0x00 or the sequence ends in `error`. Block-addressed cards skip command 16.
- R10: On success, one last 0xFF is issued with `spi_cs_n` = 0. After that, `done` = 1, `spi_cs_n` = 1, `spi_en` stays 1 and no further byte is issued.
- R11: `start` restarts the sequence from the wake-up bytes at any point. It clears `done`, `error` and `block_addressed`, and a byte exchange still in flight is allowed to finish first.
- R12: Only one byte exchange is outstanding at a time. No byte is issued between an issue strobe and its acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin or restart bring-up |
| spi_go | output | 1 | One-cycle strobe issuing a byte |
| spi_txd | output | 8 | Byte to send, valid with `spi_go` |
| spi_ack | input | 1 | One-cycle strobe ending the outstanding exchange |
| spi_rxd | input | 8 | Received byte, valid with `spi_ack` |
| spi_cs_n | output | 1 | Card chip select, active low |
| spi_en | output | 1 | Port enable, high from start onward |
| done | output | 1 | Bring-up finished successfully |
| error | output | 1 | Bring-up failed |
| block_addressed | output | 1 | Card uses block numbers rather than byte offsets |

## Verification
The assertions check on every cycle that issues never overlap and that wake-up bytes are 0xFF with chip select high. They also check that `done` and `error` never coexist, that the port falls silent once either is set, that `start` clears the result flags, and that the addressing flag holds steady while `done` is high. Only the bench scenarios can show the exact byte sequences, because they depend on what the card answers. A card model answers with chosen delays and responses. This covers the high-capacity and byte-addressed branches, both ways into the legacy path, repeated busy answers, a bad echo, rejected responses, the 256-byte timeouts and a restart in mid-sequence.

// File: rtl/sdi_pkg.sv
package sdi_pkg;

    localparam logic [7:0] FILL_BYTE   = 8'hFF;
    localparam logic [7:0] R1_MASK     = 8'h7E;
    localparam logic [7:0] ECHO_VOLT   = 8'h01;
    localparam logic [7:0] ECHO_PAT    = 8'hAA;
    localparam int         FRAME_BYTES = 6;
    localparam int         TAIL_BYTES  = 4;
    localparam int         CAP_BIT     = 6;

    typedef enum logic [3:0] {
        PH_IDLE, PH_DRAIN, PH_WAKE, PH_PRE, PH_CMD,
        PH_POLL, PH_TAIL, PH_FINISH, PH_DONE, PH_FAIL
    } phase_e;

    typedef enum logic [2:0] {
        C_RESET, C_IFCOND, C_APPPFX, C_OPCOND, C_OCR, C_BLKLEN
    } cmd_e;

    typedef struct packed {
        phase_e ph;
        cmd_e   cmd;
        logic   hc;
        logic   blk;
    } seq_t;

    function automatic logic [7:0] frame_byte(cmd_e c, logic hc, logic [2:0] i);
        logic [5:0]  idx;
        logic [31:0] arg;
        logic [7:0]  chk;
        idx = 6'd0; arg = 32'h0; chk = 8'hFF;
        case (c)
            C_RESET:  begin idx = 6'd0;  chk = 8'h95; end
            C_IFCOND: begin idx = 6'd8;  arg = 32'h0000_01AA; chk = 8'h87; end
            C_APPPFX: idx = 6'd55;
            C_OPCOND: begin idx = 6'd41; arg = hc ? 32'h4000_0000 : 32'h0; end
            C_OCR:    idx = 6'd58;
            C_BLKLEN: begin idx = 6'd16; arg = 32'h0000_0200; end
            default:  idx = 6'd0;
        endcase
        case (i)
            3'd0:    frame_byte = {2'b01, idx};
            3'd1:    frame_byte = arg[31:24];
            3'd2:    frame_byte = arg[23:16];
            3'd3:    frame_byte = arg[15:8];
            3'd4:    frame_byte = arg[7:0];
            default: frame_byte = chk;
        endcase
    endfunction

endpackage

// File: rtl/sdi_count.sv
module sdi_count #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst || clr) q <= '0;
        else if (inc)   q <= q + 1'b1;
    end
endmodule

// File: rtl/sdi_xfer.sv
module sdi_xfer (
    input  logic clk,
    input  logic rst,
    input  logic want,
    input  logic ack,
    output logic go,
    output logic pending
);
    assign go = want && !pending;

    always_ff @(posedge clk) begin
        if (rst)       pending <= 1'b0;
        else if (go)   pending <= 1'b1;
        else if (ack)  pending <= 1'b0;
    end
endmodule

// File: rtl/sdi_frame_rom.sv
module sdi_frame_rom
    import sdi_pkg::*;
(
    input  cmd_e       cmd,
    input  logic       hc,
    input  logic [2:0] idx,
    output logic [7:0] data
);
    assign data = frame_byte(cmd, hc, idx);
endmodule

// File: rtl/sd_spi_init.sv
module sd_spi_init
    import sdi_pkg::*;
#(
    parameter int WAKE_BYTES = 16,
    parameter int PRE_BYTES  = 2,
    parameter int POLL_LIMIT = 256
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    output logic       spi_go,
    output logic [7:0] spi_txd,
    input  logic       spi_ack,
    input  logic [7:0] spi_rxd,
    output logic       spi_cs_n,
    output logic       spi_en,
    output logic       done,
    output logic       error,
    output logic       block_addressed
);
    localparam int MAXC  = (POLL_LIMIT > WAKE_BYTES) ? POLL_LIMIT : WAKE_BYTES;
    localparam int CNT_W = ($clog2(MAXC) < 3) ? 3 : $clog2(MAXC);
    localparam logic [CNT_W-1:0] WAKE_LAST  = CNT_W'(WAKE_BYTES - 1);
    localparam logic [CNT_W-1:0] PRE_LAST   = CNT_W'(PRE_BYTES - 1);
    localparam logic [CNT_W-1:0] FRAME_LAST = CNT_W'(FRAME_BYTES - 1);
    localparam logic [CNT_W-1:0] POLL_LAST  = CNT_W'(POLL_LIMIT - 1);
    localparam logic [CNT_W-1:0] TAIL_LAST  = CNT_W'(TAIL_BYTES - 1);

    seq_t             ctl, nxt;
    logic [CNT_W-1:0] cnt;
    logic             cnt_clr, cnt_inc;
    logic             want, pending, fire, r1_ok;
    logic [7:0]       rom_byte;

    sdi_count #(.W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .clr(cnt_clr), .inc(cnt_inc), .q(cnt)
    );

    sdi_xfer u_xfer (
        .clk(clk), .rst(rst), .want(want), .ack(spi_ack),
        .go(spi_go), .pending(pending)
    );

    sdi_frame_rom u_rom (
        .cmd(ctl.cmd), .hc(ctl.hc), .idx(cnt[2:0]), .data(rom_byte)
    );

    // byte-issuing phases and the port pins
    always_comb begin
        want = 1'b0;
        case (ctl.ph)
            PH_WAKE, PH_PRE, PH_CMD, PH_POLL, PH_TAIL, PH_FINISH: want = !start;
            default: want = 1'b0;
        endcase
    end

    assign spi_txd  = (ctl.ph == PH_CMD) ? rom_byte : FILL_BYTE;
    assign spi_cs_n = !(ctl.ph inside {PH_PRE, PH_CMD, PH_POLL, PH_TAIL, PH_FINISH});
    assign spi_en   = (ctl.ph != PH_IDLE);
    assign done     = (ctl.ph == PH_DONE);
    assign error    = (ctl.ph == PH_FAIL);
    assign block_addressed = ctl.blk;

    assign fire  = spi_ack && pending;
    assign r1_ok = ((spi_rxd & R1_MASK) == 8'h00);

    always_comb begin
        nxt     = ctl;
        cnt_clr = 1'b0;
        cnt_inc = 1'b0;
        if (start) begin
            nxt.ph  = (pending && !spi_ack) ? PH_DRAIN : PH_WAKE;
            nxt.cmd = C_RESET;
            nxt.hc  = 1'b0;
            nxt.blk = 1'b0;
            cnt_clr = 1'b1;
        end else begin
            case (ctl.ph)
                PH_DRAIN: if (spi_ack) begin nxt.ph = PH_WAKE; cnt_clr = 1'b1; end
                PH_WAKE: if (fire) begin
                    if (cnt == WAKE_LAST) begin nxt.ph = PH_PRE; cnt_clr = 1'b1; end
                    else cnt_inc = 1'b1;
                end
                PH_PRE: if (fire) begin
                    if (cnt == PRE_LAST) begin nxt.ph = PH_CMD; cnt_clr = 1'b1; end
                    else cnt_inc = 1'b1;
                end
                PH_CMD: if (fire) begin
                    if (cnt == FRAME_LAST) begin nxt.ph = PH_POLL; cnt_clr = 1'b1; end
                    else cnt_inc = 1'b1;
                end
                PH_POLL: if (fire) begin
                    if (!spi_rxd[7]) begin
                        cnt_clr = 1'b1;
                        nxt.ph  = PH_PRE;
                        case (ctl.cmd)
                            C_RESET:  if (r1_ok) nxt.cmd = C_IFCOND; else nxt.ph = PH_FAIL;
                            C_IFCOND: if (r1_ok) nxt.ph = PH_TAIL;
                                      else begin nxt.hc = 1'b0; nxt.cmd = C_APPPFX; end
                            C_APPPFX: if (r1_ok) nxt.cmd = C_OPCOND; else nxt.ph = PH_FAIL;
                            C_OPCOND: if (spi_rxd == 8'h00) nxt.cmd = ctl.hc ? C_OCR : C_BLKLEN;
                                      else if (spi_rxd == 8'h01) nxt.cmd = C_APPPFX;
                                      else nxt.ph = PH_FAIL;
                            C_OCR:    nxt.ph = PH_TAIL;
                            C_BLKLEN: nxt.ph = (spi_rxd == 8'h00) ? PH_FINISH : PH_FAIL;
                            default:  nxt.ph = PH_FAIL;
                        endcase
                    end else if (cnt == POLL_LAST) begin
                        cnt_clr = 1'b1;
                        if (ctl.cmd == C_IFCOND) begin
                            nxt.ph = PH_PRE; nxt.hc = 1'b0; nxt.cmd = C_APPPFX;
                        end else nxt.ph = PH_FAIL;
                    end else cnt_inc = 1'b1;
                end
                PH_TAIL: if (fire) begin
                    cnt_inc = 1'b1;
                    if (ctl.cmd == C_IFCOND) begin
                        if (cnt == CNT_W'(2) && spi_rxd != ECHO_VOLT) nxt.ph = PH_FAIL;
                        if (cnt == TAIL_LAST) begin
                            cnt_clr = 1'b1;
                            if (spi_rxd != ECHO_PAT) nxt.ph = PH_FAIL;
                            else begin nxt.ph = PH_PRE; nxt.hc = 1'b1; nxt.cmd = C_APPPFX; end
                        end
                    end else begin
                        if (cnt == '0) nxt.blk = spi_rxd[CAP_BIT];
                        if (cnt == TAIL_LAST) begin
                            cnt_clr = 1'b1;
                            if (ctl.blk) nxt.ph = PH_FINISH;
                            else begin nxt.ph = PH_PRE; nxt.cmd = C_BLKLEN; end
                        end
                    end
                end
                PH_FINISH: if (fire) nxt.ph = PH_DONE;
                default: nxt = ctl;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ctl <= '{ph: PH_IDLE, cmd: C_RESET, hc: 1'b0, blk: 1'b0};
        else     ctl <= nxt;
    end

    // R12: an issue strobe is never followed directly by another
    assert_single_issue_R12: assert property (@(posedge clk) disable iff (rst)
        spi_go |=> !spi_go);

    // R2: wake-up bytes are fill bytes with the card deselected
    assert_wake_deselected_R2: assert property (@(posedge clk) disable iff (rst)
        (ctl.ph == PH_WAKE && spi_go) |-> (spi_cs_n && spi_txd == FILL_BYTE));

    // R11: start wipes the result flags
    assert_start_clears_R11: assert property (@(posedge clk) disable iff (rst)
        start |=> (!done && !error && !block_addressed));

    // R10: the port is silent once a result is held
    assert_quiet_after_end_R10: assert property (@(posedge clk) disable iff (rst)
        (done || error) |-> !spi_go);

    // R8: addressing flag holds while done stays high
    assert_blk_stable_R8: assert property (@(posedge clk) disable iff (rst)
        (done && $past(done)) |-> $stable(block_addressed));

    // R1: success and failure are exclusive
    assert_result_exclusive_R1: assert property (@(posedge clk) disable iff (rst)
        !(done && error));

endmodule

// File: tb/sim_sd_spi_init.sv
module sim_sd_spi_init;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic       go, cs_n, en, done, error, blk;
    logic [7:0] txd;
    logic       ack = 1'b0;
    logic [7:0] rxd = 8'hFF;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int byte_n = 0;

    // card model configuration
    int   d = 1;
    logic [7:0] cmd0_r1 = 8'h01;
    bit   cmd0_silent = 0;
    int   cmd8_mode = 0;
    int   busy = 0;
    logic [7:0] acmd_r1 = 8'h00;
    bit   ccs = 0;
    logic [7:0] cmd16_r1 = 8'h00;
    bit   mdl_reset = 0;

    bit   exp_ok, exp_blk;
    logic [12:0] exp_q[$];   // {req[3:0], cs_n, byte}

    always #10 clk = ~clk;
    always @(posedge clk) cycles++;

    sd_spi_init u0 (
        .clk(clk), .rst(rst), .start(start), .spi_go(go), .spi_txd(txd),
        .spi_ack(ack), .spi_rxd(rxd), .spi_cs_n(cs_n), .spi_en(en),
        .done(done), .error(error), .block_addressed(blk)
    );

    task automatic check(string req, logic [31:0] got, logic [31:0] want, string what);
        checks++;
        if (got !== want) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, want);
        end
    endtask

    task automatic push(int req, bit c, logic [7:0] b);
        exp_q.push_back({4'(req), c, b});
    endtask

    task automatic ff(int req, int n);
        for (int i = 0; i < n; i++) push(req, 1'b0, 8'hFF);
    endtask

    task automatic frame(int req, logic [7:0] b0, logic [7:0] b1, logic [7:0] b2,
                         logic [7:0] b3, logic [7:0] b4, logic [7:0] b5);
        ff(3, 2);
        push(req, 0, b0); push(req, 0, b1); push(req, 0, b2);
        push(req, 0, b3); push(req, 0, b4); push(req, 0, b5);
    endtask

    // expected byte stream derived from the requirements and the card config
    task automatic build();
        bit hc;
        hc = 0; exp_ok = 0; exp_blk = 0;
        for (int i = 0; i < 16; i++) push(2, 1'b1, 8'hFF);          // R2
        frame(3, 8'h40, 8'h00, 8'h00, 8'h00, 8'h00, 8'h95);          // R3
        if (cmd0_silent) begin ff(4, 256); return; end              // R4
        ff(4, d + 1);
        if ((cmd0_r1 & 8'h7E) != 0) return;                         // R5
        frame(3, 8'h48, 8'h00, 8'h00, 8'h01, 8'hAA, 8'h87);
        case (cmd8_mode)
            1: ff(4, 256);                                          // R6 timeout
            2: ff(4, d + 1);                                        // R6 rejected
            3: begin ff(4, d + 1); ff(6, 3); return; end            // R6 bad echo
            default: begin ff(4, d + 1); ff(6, 4); hc = 1; end
        endcase
        for (int k = 0; k <= busy; k++) begin                       // R7
            frame(7, 8'h77, 8'h00, 8'h00, 8'h00, 8'h00, 8'hFF);
            ff(4, d + 1);
            frame(7, 8'h69, hc ? 8'h40 : 8'h00, 8'h00, 8'h00, 8'h00, 8'hFF);
            ff(4, d + 1);
        end
        if (acmd_r1 != 0) return;
        if (hc) begin                                               // R8
            frame(8, 8'h7A, 8'h00, 8'h00, 8'h00, 8'h00, 8'hFF);
            ff(4, d + 1);
            ff(8, 4);
            exp_blk = ccs;
        end
        if (!exp_blk) begin                                         // R9
            frame(9, 8'h50, 8'h00, 8'h00, 8'h02, 8'h00, 8'hFF);
            ff(4, d + 1);
            if (cmd16_r1 != 0) return;
        end
        push(10, 1'b0, 8'hFF);                                      // R10
        exp_ok = 1;
    endtask

    // card model plus scoreboard monitor
    initial begin
        bit         in_frame = 0;
        int         fidx = 0;
        int         busy_left = 0;
        logic [7:0] fr[6];
        logic [7:0] rq[$];
        logic [7:0] rx;
        logic [12:0] e;
        forever begin
            @(negedge clk);
            if (mdl_reset) begin
                in_frame = 0; rq.delete(); busy_left = busy; mdl_reset = 0;
            end
            if (go === 1'b1) begin
                byte_n++;
                checks++;
                if (exp_q.size() == 0) begin
                    errors++;
                    $display("FAIL R10 unexpected byte: got %h/%b expected none", txd, cs_n);
                end else begin
                    e = exp_q.pop_front();
                    if ({cs_n, txd} !== e[8:0]) begin
                        errors++;
                        $display("FAIL R%0d byte %0d: got cs=%b %h expected cs=%b %h",
                                 e[12:9], byte_n, cs_n, txd, e[8], e[7:0]);
                    end
                end
                rx = (rq.size() > 0) ? rq.pop_front() : 8'hFF;
                if (!cs_n) begin
                    if (!in_frame && txd[7:6] == 2'b01) begin
                        in_frame = 1; fidx = 1; fr[0] = txd; rq.delete();
                    end else if (in_frame) begin
                        fr[fidx] = txd; fidx++;
                        if (fidx == 6) begin
                            in_frame = 0;
                            for (int i = 0; i < d; i++) rq.push_back(8'hFF);
                            case (fr[0] & 8'h3F)
                                0:  if (!cmd0_silent) rq.push_back(cmd0_r1); else rq.delete();
                                8:  case (cmd8_mode)
                                        1: rq.delete();
                                        2: rq.push_back(8'h05);
                                        3: begin rq.push_back(8'h01); rq.push_back(8'h00);
                                                 rq.push_back(8'h00); rq.push_back(8'h02);
                                                 rq.push_back(8'hAA); end
                                        default: begin rq.push_back(8'h01); rq.push_back(8'h00);
                                                 rq.push_back(8'h00); rq.push_back(8'h01);
                                                 rq.push_back(8'hAA); end
                                    endcase
                                55: rq.push_back(8'h01);
                                41: if (busy_left > 0) begin rq.push_back(8'h01); busy_left--; end
                                    else rq.push_back(acmd_r1);
                                58: begin rq.push_back(8'h00); rq.push_back(ccs ? 8'hC0 : 8'h80);
                                          rq.push_back(8'hFF); rq.push_back(8'h80);
                                          rq.push_back(8'h00); end
                                16: rq.push_back(cmd16_r1);
                                default: rq.push_back(8'h04);
                            endcase
                        end
                    end
                end
                @(posedge clk); #2;
                ack = 1'b1; rxd = rx;
                @(negedge clk);
                check("R12", go, 1'b0, "issue while exchange outstanding");
                @(posedge clk); #2;
                ack = 1'b0; rxd = 8'hFF;
            end
        end
    end

    task automatic pulse_start();
        @(posedge clk); #2; start = 1'b1;
        @(posedge clk); #2; start = 1'b0;
    endtask

    task automatic run(string req, string name);
        int n;
        exp_q.delete();
        mdl_reset = 1;
        build();
        pulse_start();
        @(negedge clk); @(negedge clk);
        check("R11", {done, error, blk}, 3'b000, {name, " flags cleared by start"});
        check("R2", {en, cs_n}, 2'b11, {name, " wake-up port state"});
        n = 0;
        while (!(done || error) && n < 5000) begin @(negedge clk); n++; end
        repeat (10) @(negedge clk);
        check(req, done, exp_ok, {name, " done"});
        check(req, error, !exp_ok, {name, " error"});
        check("R8", blk, exp_blk, {name, " block_addressed"});
        check("R10", {cs_n, en}, 2'b11, {name, " final port state"});
        check(req, exp_q.size(), 0, {name, " bytes still expected"});
    endtask

    initial begin
        while (cycles < 190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk); #2;
        rst = 1'b0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1", {done, error, blk, en, cs_n, go}, 6'b000010, "reset outputs");

        // R8 high-capacity card, busy twice
        d = 1; busy = 2; ccs = 1; run("R8", "hc_block");
        // R9 version-2 card reporting byte addressing
        d = 3; busy = 0; ccs = 0; run("R9", "v2_byte");
        // R6 legacy path via rejected interface-condition response
        d = 2; cmd8_mode = 2; busy = 1; run("R6", "legacy_reject");
        // R6 legacy path via timeout (R4 256-byte poll)
        d = 1; cmd8_mode = 1; busy = 0; run("R4", "legacy_timeout");
        // R6 bad echo byte
        cmd8_mode = 3; run("R6", "bad_echo");
        // R5 reset command response failing the mask
        cmd8_mode = 0; cmd0_r1 = 8'h05; run("R5", "reset_bad");
        // R5 reset command response 0x00 accepted
        cmd0_r1 = 8'h00; ccs = 1; run("R5", "reset_zero_ok");
        // R4 reset command never answers
        cmd0_r1 = 8'h01; cmd0_silent = 1; run("R4", "reset_timeout");
        // R7 operating-condition rejection
        cmd0_silent = 0; busy = 1; acmd_r1 = 8'h05; run("R7", "opcond_bad");
        // R9 block-length rejection on legacy card
        acmd_r1 = 8'h00; busy = 0; cmd8_mode = 2; cmd16_r1 = 8'h01; run("R9", "blklen_bad");

        // R11 restart in mid-sequence
        cmd8_mode = 0; cmd16_r1 = 8'h00; busy = 3; ccs = 1; d = 1;
        exp_q.delete(); mdl_reset = 1; build();
        byte_n = 0;
        pulse_start();
        while (byte_n < 45) @(negedge clk);
        ccs = 0; busy = 0;
        run("R11", "restart");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule